// File: doc/BRIEF.md
# PCM Serial Voice Port

This block is the digital side of a single-channel telephone voice codec's serial interface. Each 8 kHz frame carries one 8-bit receive slot and one 8-bit transmit slot. The block runs on a fast system clock and samples the serial bit clock, both frame syncs and the serial data input through two-flop synchronizers. All four signals pass through the same pipeline depth, so their relative phase is kept. A received byte is gathered on bit-clock falling edges, starting at the receive sync's rising edge. It is then presented on a parallel port with a one-cycle strobe. A parallel transmit byte is shifted out MSB first on bit-clock rising edges, starting at the transmit sync's rising edge. The output is open-drain style: the block pulls the line low for a 0 bit and releases it otherwise, and it drives only inside its 8-bit slot.

A power state machine with four states controls both directions: DOWN (code 0), SAVE (code 1), ARM (code 2) and RUN (code 3). The transitions are:
- DOWN is entered from any state while the power-down input is low.
- DOWN → ARM when that input rises, or DOWN → SAVE if the clocks are stalled at that moment.
- ARM → RUN on the first transmit sync rising edge, and that frame is served.
- ARM or RUN → SAVE when the bit clock or the transmit sync has shown no edge for `TIMEOUT_CYC` system clocks.
- SAVE → ARM once both have toggled again.

An even-bit inversion option maps parallel codes to line codes for the A-law convention. A loopback mode returns each received line byte in the next transmit slot and silences the parallel receive port.

Top module: `pcm_voice_port`

## Requirements
- R1: While `pd_n` is low, `pwr_state` reads 0 (DOWN) from the next system clock, and `pcm_slot` is 0.
- R2: After `pd_n` rises with clocks running, `pwr_state` reads 2 (ARM). The next transmit sync rising edge moves it to 3 (RUN), and that same frame is transmitted and received.
- R3: In RUN, the bit on `pcm_din` at the first bit-clock falling edge after a receive sync rising edge is the MSB. Eight falling edges form the byte. The byte appears on `rx_word` together with a `rx_valid` pulse exactly one system clock wide.
- R4: In RUN, a transmit sync rising edge starts a slot whose first bit is the MSB. Each later bit-clock rising edge advances one bit. `pcm_pull_low` is 1 for a 0 bit and 0 for a 1 bit, and `pcm_slot` rises only in RUN.
- R5: `pcm_slot` falls at the eighth bit-clock rising edge after the slot start, and it is 0 outside slots.
- R6: With `alaw_en`=1 the line byte is the parallel byte XOR 8'h55 in both directions (parallel 8'h80 is sent as 8'hD5, line 8'hAA is received as 8'hFF). With `alaw_en`=0 bytes pass unchanged.
- R7: A bit clock held static for `TIMEOUT_CYC` system clocks puts `pwr_state` at 1 (SAVE) and releases the output.
- R8: A transmit sync held static for `TIMEOUT_CYC` system clocks, with the bit clock running, also gives SAVE.
- R9: Out of SAVE, the first transmit sync edge with the bit clock running leads to ARM, and that frame is not served. The following frame is served in RUN.
- R10: With `loop_en`=1, the transmit slot of frame N+1 carries the raw line byte received in frame N, and `tx_word` has no effect.
- R11: With `loop_en`=1, `rx_valid` stays 0.
- R12: Power-down in the middle of a receive byte discards the partial byte: no `rx_valid` follows until a new complete frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the fastest bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down request, active low, synchronous to clk |
| loop_en | input | 1 | Loopback mode select |
| alaw_en | input | 1 | Even-bit inversion enable |
| bclk | input | 1 | Serial bit clock (asynchronous) |
| tx_sync | input | 1 | Transmit frame sync (asynchronous) |
| rx_sync | input | 1 | Receive frame sync (asynchronous) |
| pcm_din | input | 1 | Serial receive data |
| tx_word | input | SLOT_W | Parallel byte to transmit |
| rx_word | output | SLOT_W | Last received parallel byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_word |
| pcm_slot | output | 1 | High while the transmit slot is active |
| pcm_pull_low | output | 1 | Pull the open-drain line low |
| pwr_state | output | 2 | Power state: 0 DOWN, 1 SAVE, 2 ARM, 3 RUN |

## Verification
The bound checker watches, on every cycle, several rules:
- power-down forcing DOWN and a released output on the next cycle;
- a stall forcing SAVE;
- the receive strobe lasting a single cycle and staying silent in loopback;
- a slot opening only in RUN and never spanning more than eight bit-clock rises.

Byte values, bit order, even-bit inversion, the one-frame loopback delay, the frame skipped while leaving SAVE and the discarding of a partial byte depend on whole frames of stimulus. Only the bench's scoreboard scenarios can show these.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        ST_DOWN = 2'd0,
        ST_SAVE = 2'd1,
        ST_ARM  = 2'd2,
        ST_RUN  = 2'd3
    } port_state_t;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SLOT = 1'b1
    } tx_state_t;

    // index of each asynchronous input inside the synchronizer vector
    localparam int unsigned IDX_BCLK  = 0;
    localparam int unsigned IDX_TSYNC = 1;
    localparam int unsigned IDX_RSYNC = 2;
    localparam int unsigned IDX_DIN   = 3;
    localparam int unsigned N_ASYNC   = 4;

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_chan
        logic [STAGES:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '0;
            end else begin
                pipe <= {pipe[STAGES-1:0], async_in[g]};
            end
        end

        assign lvl[g]  = pipe[STAGES-1];
        assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
        assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
    end

endmodule

// File: rtl/pcm_activity_mon.sv
module pcm_activity_mon #(
    parameter int unsigned N_WATCH     = 2,
    parameter int unsigned TIMEOUT_CYC = 25000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_WATCH-1:0] edge_seen,
    output logic               stalled
);

    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

    logic [N_WATCH-1:0] expired;

    for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
        logic [CNT_W-1:0] quiet_cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                quiet_cnt <= '0;
            end else if (edge_seen[g]) begin
                quiet_cnt <= '0;
            end else if (quiet_cnt != LIMIT) begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end

        assign expired[g] = (quiet_cnt == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stalled <= 1'b0;
        end else begin
            stalled <= |expired;
        end
    end

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
    import pcm_port_pkg::*;
#(
    parameter int unsigned SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              frame_start,
    input  logic              bit_strobe,
    input  logic              din,
    output logic              word_done,
    output logic [SLOT_W-1:0] word
);

    localparam int unsigned CNT_W = $clog2(SLOT_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_W - 1);

    rx_state_t         state, state_nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [SLOT_W-1:0] shreg;
    logic              take_bit;
    logic              last_bit;

    assign take_bit = (state == RX_SHIFT) && bit_strobe && !frame_start;
    assign last_bit = take_bit && (bit_cnt == LAST);

    always_comb begin
        state_nxt = state;
        if (!run_en) begin
            state_nxt = RX_IDLE;
        end else if (frame_start) begin
            state_nxt = RX_SHIFT;
        end else begin
            unique case (state)
                RX_IDLE:  state_nxt = RX_IDLE;
                RX_SHIFT: if (last_bit) state_nxt = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            word      <= '0;
            word_done <= 1'b0;
        end else if (!run_en || frame_start) begin
            bit_cnt   <= '0;
            word_done <= 1'b0;
        end else begin
            word_done <= last_bit;
            if (take_bit) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {shreg[SLOT_W-2:0], din};
                if (last_bit) begin
                    word <= {shreg[SLOT_W-2:0], din};
                end
            end
        end
    end

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser
    import pcm_port_pkg::*;
#(
    parameter int unsigned SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              frame_start,
    input  logic              bit_strobe,
    input  logic [SLOT_W-1:0] word,
    output logic              slot_on,
    output logic              bit_out
);

    localparam int unsigned CNT_W = $clog2(SLOT_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_W - 1);

    tx_state_t         state, state_nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [SLOT_W-1:0] shreg;
    logic              advance;

    assign advance = (state == TX_SLOT) && bit_strobe && !frame_start;

    always_comb begin
        state_nxt = state;
        if (!run_en) begin
            state_nxt = TX_IDLE;
        end else if (frame_start) begin
            state_nxt = TX_SLOT;
        end else begin
            unique case (state)
                TX_IDLE: state_nxt = TX_IDLE;
                TX_SLOT: if (advance && bit_cnt == LAST) state_nxt = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '1;
        end else if (!run_en) begin
            bit_cnt <= '0;
        end else if (frame_start) begin
            bit_cnt <= '0;
            shreg   <= word;
        end else if (advance) begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[SLOT_W-2:0], 1'b1};
        end
    end

    assign slot_on = (state == TX_SLOT);
    assign bit_out = shreg[SLOT_W-1];

endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
    import pcm_port_pkg::*;
#(
    parameter int unsigned SLOT_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TIMEOUT_CYC = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              loop_en,
    input  logic              alaw_en,
    input  logic              bclk,
    input  logic              tx_sync,
    input  logic              rx_sync,
    input  logic              pcm_din,
    input  logic [SLOT_W-1:0] tx_word,
    output logic [SLOT_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              pcm_slot,
    output logic              pcm_pull_low,
    output logic [1:0]        pwr_state
);

    localparam logic [SLOT_W-1:0] EVEN_MASK = {(SLOT_W/2){2'b01}};

    logic [N_ASYNC-1:0] a_lvl, a_rise, a_fall;
    logic bclk_rise, bclk_fall, txs_rise, txs_fall, rxs_rise, din_lvl;
    logic stalled;
    logic run_en;
    logic rx_done, slot_bit;
    logic [SLOT_W-1:0] rx_raw, loop_q, line_mask, tx_line;
    port_state_t state, state_nxt;
    logic unused_sync_bits;

    pcm_edge_sync #(
        .WIDTH  (N_ASYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pcm_din, rx_sync, tx_sync, bclk}),
        .lvl      (a_lvl),
        .rise     (a_rise),
        .fall     (a_fall)
    );

    assign bclk_rise = a_rise[IDX_BCLK];
    assign bclk_fall = a_fall[IDX_BCLK];
    assign txs_rise  = a_rise[IDX_TSYNC];
    assign txs_fall  = a_fall[IDX_TSYNC];
    assign rxs_rise  = a_rise[IDX_RSYNC];
    assign din_lvl   = a_lvl[IDX_DIN];
    assign unused_sync_bits = ^{a_lvl[IDX_RSYNC:IDX_BCLK], a_fall[IDX_DIN:IDX_RSYNC], a_rise[IDX_DIN]};

    pcm_activity_mon #(
        .N_WATCH     (2),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_seen ({txs_rise | txs_fall, bclk_rise | bclk_fall}),
        .stalled   (stalled)
    );

    // power state machine
    always_comb begin
        state_nxt = state;
        if (!pd_n) begin
            state_nxt = ST_DOWN;
        end else begin
            unique case (state)
                ST_DOWN: state_nxt = stalled ? ST_SAVE : ST_ARM;
                ST_SAVE: if (!stalled) state_nxt = ST_ARM;
                ST_ARM: begin
                    if (stalled)       state_nxt = ST_SAVE;
                    else if (txs_rise) state_nxt = ST_RUN;
                end
                ST_RUN:  if (stalled) state_nxt = ST_SAVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_DOWN;
        end else begin
            state <= state_nxt;
        end
    end

    assign run_en    = (state_nxt == ST_RUN);
    assign line_mask = alaw_en ? EVEN_MASK : '0;
    assign tx_line   = loop_en ? loop_q : (tx_word ^ line_mask);

    pcm_rx_deser #(
        .SLOT_W (SLOT_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .frame_start (rxs_rise),
        .bit_strobe  (bclk_fall),
        .din         (din_lvl),
        .word_done   (rx_done),
        .word        (rx_raw)
    );

    pcm_tx_ser #(
        .SLOT_W (SLOT_W)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .frame_start (txs_rise),
        .bit_strobe  (bclk_rise),
        .word        (tx_line),
        .slot_on     (pcm_slot),
        .bit_out     (slot_bit)
    );

    // output process: parallel receive port and loopback holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
            loop_q   <= '1;
        end else begin
            rx_valid <= rx_done && !loop_en;
            if (rx_done) begin
                loop_q <= rx_raw;
                if (!loop_en) begin
                    rx_word <= rx_raw ^ line_mask;
                end
            end
        end
    end

    assign pcm_pull_low = pcm_slot & ~slot_bit;
    assign pwr_state    = state;

endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_n,
    input logic       loop_en,
    input logic       bclk_rise,
    input logic       stalled,
    input logic       pcm_slot,
    input logic       rx_valid,
    input logic [1:0] pwr_state
);

    logic [3:0] rises_in_slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rises_in_slot <= '0;
        end else if (!pcm_slot) begin
            rises_in_slot <= '0;
        end else if (bclk_rise) begin
            rises_in_slot <= rises_in_slot + 1'b1;
        end
    end

    a_r1_down_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (pwr_state == 2'd0) && !pcm_slot);

    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r4_slot_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcm_slot) |-> (pwr_state == 2'd3));

    a_r5_slot_length: assert property (@(posedge clk) disable iff (!rst_n)
        rises_in_slot <= 4'd8);

    a_r7_stall_to_save: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && pd_n) |=> (pwr_state == 2'd1));

    a_r11_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(loop_en) |-> !rx_valid);

endmodule

bind pcm_voice_port pcm_voice_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .loop_en   (loop_en),
    .bclk_rise (bclk_rise),
    .stalled   (stalled),
    .pcm_slot  (pcm_slot),
    .rx_valid  (rx_valid),
    .pwr_state (pwr_state)
);

// File: tb/pcm_voice_port_tb.sv
module pcm_voice_port_tb;

    localparam int unsigned TMO     = 1300;
    localparam int unsigned HALF    = 8;
    localparam int unsigned PERIODS = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_n = 1'b0;
    logic       loop_en = 1'b0;
    logic       alaw_en = 1'b0;
    logic       bclk = 1'b0;
    logic       tx_sync = 1'b0;
    logic       rx_sync = 1'b0;
    logic       pcm_din = 1'b1;
    logic [7:0] tx_word = 8'h00;
    logic [7:0] rx_word;
    logic       rx_valid;
    logic       pcm_slot;
    logic       pcm_pull_low;
    logic [1:0] pwr_state;

    int n_checks = 0;
    int n_errors = 0;
    int rx_seen  = 0;
    int rx_mark  = 0;

    logic [7:0] tx_q[$];
    string      tx_tag_q[$];
    logic [7:0] rx_q[$];
    string      rx_tag_q[$];

    always #5 clk = ~clk;

    pcm_voice_port #(
        .SLOT_W      (8),
        .SYNC_STAGES (2),
        .TIMEOUT_CYC (TMO)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pd_n         (pd_n),
        .loop_en      (loop_en),
        .alaw_en      (alaw_en),
        .bclk         (bclk),
        .tx_sync      (tx_sync),
        .rx_sync      (rx_sync),
        .pcm_din      (pcm_din),
        .tx_word      (tx_word),
        .rx_word      (rx_word),
        .rx_valid     (rx_valid),
        .pcm_slot     (pcm_slot),
        .pcm_pull_low (pcm_pull_low),
        .pwr_state    (pwr_state)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: one frame of PERIODS bit clocks; expectations go to the scoreboard
    task automatic frame(input bit tsync, input bit rsync, input logic [7:0] rx_line,
                         input bit exp_tx, input logic [7:0] tx_exp, input string tx_tag,
                         input bit exp_rx, input logic [7:0] rx_exp, input string rx_tag,
                         input bit abort);
        if (exp_tx) begin
            tx_q.push_back(tx_exp);
            tx_tag_q.push_back(tx_tag);
        end
        if (exp_rx) begin
            rx_q.push_back(rx_exp);
            rx_tag_q.push_back(rx_tag);
        end
        for (int k = 0; k < PERIODS; k++) begin
            @(negedge clk);
            bclk    = 1'b1;
            tx_sync = tsync && (k == 0);
            rx_sync = rsync && (k == 0);
            pcm_din = (k < 8) ? rx_line[7-k] : 1'b1;
            if (abort) pd_n = (k != 4);
            repeat (HALF) @(negedge clk);
            bclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    task automatic quiet(input int n);
        bclk    = 1'b0;
        tx_sync = 1'b0;
        rx_sync = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // transmit monitor
    initial begin : tx_mon
        logic [7:0] got;
        logic [7:0] exp_b;
        string      tag;
        bit         held;
        forever begin
            @(negedge clk);
            if (pcm_slot) begin
                got  = 8'h00;
                held = 1'b1;
                repeat (7) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    got[7-i] = ~pcm_pull_low;
                    held     = held & pcm_slot;
                    if (i < 7) repeat (16) @(negedge clk);
                end
                if (tx_q.size() == 0) begin
                    check(1'b0, "R5", "slot with nothing expected", got, 0);
                end else begin
                    exp_b = tx_q.pop_front();
                    tag   = tx_tag_q.pop_front();
                    check(held && got == exp_b, tag, "transmitted byte", got, exp_b);
                end
                repeat (16) @(negedge clk);
                check(!pcm_slot, "R5", "slot released after 8 bits", pcm_slot, 0);
            end
        end
    end

    // receive monitor
    initial begin : rx_mon
        logic [7:0] exp_b;
        string      tag;
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                rx_seen++;
                if (rx_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected rx_valid", rx_word, 0);
                end else begin
                    exp_b = rx_q.pop_front();
                    tag   = rx_tag_q.pop_front();
                    check(rx_word == exp_b, tag, "received byte", rx_word, exp_b);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        repeat (10) @(negedge clk);
        check(pwr_state == 2'd0, "R1", "state in reset", pwr_state, 0);
        check(!pcm_slot, "R1", "slot in reset", pcm_slot, 0);
        check(!rx_valid, "R1", "rx_valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(pwr_state == 2'd0, "R1", "state with pd_n low", pwr_state, 0);
        pd_n = 1'b1;
        repeat (2) @(negedge clk);
        check(pwr_state == 2'd2, "R2", "state after power-up", pwr_state, 2);

        // mu-law frames: line equals parallel
        tx_word = 8'h80;
        frame(1, 1, 8'h00, 1, 8'h80, "R2", 1, 8'h00, "R2", 0);
        check(pwr_state == 2'd3, "R2", "state after first sync", pwr_state, 3);
        tx_word = 8'hFF;
        frame(1, 1, 8'h7F, 1, 8'hFF, "R4", 1, 8'h7F, "R3", 0);
        tx_word = 8'h7F;
        frame(1, 1, 8'hFF, 1, 8'h7F, "R4", 1, 8'hFF, "R3", 0);
        tx_word = 8'h00;
        frame(1, 1, 8'hA5, 1, 8'h00, "R4", 1, 8'hA5, "R3", 0);

        // even-bit inversion
        alaw_en = 1'b1;
        tx_word = 8'h80;
        frame(1, 1, 8'hAA, 1, 8'hD5, "R6", 1, 8'hFF, "R6", 0);
        tx_word = 8'h00;
        frame(1, 1, 8'h2A, 1, 8'h55, "R6", 1, 8'h7F, "R6", 0);

        // loopback: frame N+1 carries line byte of frame N, tx_word ignored
        alaw_en = 1'b0;
        loop_en = 1'b1;
        tx_word = 8'h33;
        rx_mark = rx_seen;
        frame(1, 1, 8'h96, 1, 8'h2A, "R10", 0, 8'h00, "", 0);
        frame(1, 1, 8'h4B, 1, 8'h96, "R10", 0, 8'h00, "", 0);
        tx_word = 8'hC3;
        frame(1, 1, 8'hE1, 1, 8'h4B, "R10", 0, 8'h00, "", 0);
        check(rx_seen == rx_mark, "R11", "rx strobes in loopback", rx_seen - rx_mark, 0);
        loop_en = 1'b0;
        tx_word = 8'h3C;
        frame(1, 1, 8'h5A, 1, 8'h3C, "R10", 1, 8'h5A, "R3", 0);

        // stopped bit clock
        quiet(TMO + 200);
        check(pwr_state == 2'd1, "R7", "state with static bit clock", pwr_state, 1);
        check(!pcm_slot, "R7", "slot in save", pcm_slot, 0);
        tx_word = 8'h69;
        frame(1, 1, 8'h12, 0, 8'h00, "", 0, 8'h00, "", 0);
        check(pwr_state == 2'd2, "R9", "state after wake sync", pwr_state, 2);
        frame(1, 1, 8'h34, 1, 8'h69, "R9", 1, 8'h34, "R9", 0);
        check(pwr_state == 2'd3, "R9", "state after second sync", pwr_state, 3);

        // static transmit sync with running bit clock
        frame(0, 0, 8'hFF, 0, 8'h00, "", 0, 8'h00, "", 0);
        frame(0, 0, 8'hFF, 0, 8'h00, "", 0, 8'h00, "", 0);
        frame(0, 0, 8'hFF, 0, 8'h00, "", 0, 8'h00, "", 0);
        check(pwr_state == 2'd1, "R8", "state with static sync", pwr_state, 1);
        tx_word = 8'h0F;
        frame(1, 1, 8'h77, 0, 8'h00, "", 0, 8'h00, "", 0);
        frame(1, 1, 8'h88, 1, 8'h0F, "R9", 1, 8'h88, "R9", 0);

        // power-down in the middle of a receive byte
        rx_mark = rx_seen;
        frame(0, 1, 8'hC6, 0, 8'h00, "", 0, 8'h00, "", 1);
        check(rx_seen == rx_mark, "R12", "strobe after aborted byte", rx_seen - rx_mark, 0);
        check(pwr_state == 2'd2, "R12", "state after power-down pulse", pwr_state, 2);
        tx_word = 8'hE7;
        frame(1, 1, 8'h3A, 1, 8'hE7, "R12", 1, 8'h3A, "R12", 0);

        quiet(300);
        check(tx_q.size() == 0, "R4", "transmit items left", tx_q.size(), 0);
        check(rx_q.size() == 0, "R3", "receive items left", rx_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule